// File: doc/BRIEF.md
# Pulse-Frequency Step Generator

This block turns a signed velocity command into a step pulse and a direction level for a stepper drive. A prescaler derives a single-cycle tick from the system clock. On every tick the magnitude of the command is added into a phase accumulator. Each carry out of the accumulator requests one step pulse, so the step rate is proportional to the command magnitude. The sign of the command gives the direction used on the next pulse.

The sequencer holds each pulse active for a programmed number of ticks. It then keeps the line inactive for at least that many ticks, so the duty cycle never goes above one half. A request that arrives while a pulse or its off window is still running is kept as one pending request, and any further requests in that window are lost. The direction level is updated only on the tick where a pulse begins, and it holds until the next pulse begins. Both outputs have a polarity select that works independently of the other.

The command, divider, width and polarity inputs are plain level controls sampled on ticks. The polarity inputs are expected to be static during operation. They are applied combinationally to the outputs. There is no handshake: the command is a continuously valid level with no back-pressure. The outputs are free-running levels that the drive must accept at the programmed rate.

Top module: `pfm_step_gen`

## Requirements
- R1: On each tick the unsigned magnitude of `cmd` (two's complement; the most negative value gives a magnitude of 2^(CMD_W-1)) is added into a CMD_W-bit accumulator. A carry out requests a pulse, so the long-run pulse rate is |cmd| * f_tick / 2^CMD_W, as long as that rate is below the cap of R5.
- R2: A tick occurs once every `div_sel`+1 system clocks. `step_out` and `dir_out` change only on the clock edge of a tick.
- R3: A pulse stays active for exactly N ticks, where N = `width_sel`. A `width_sel` of 0 is treated as 1.
- R4: After every pulse, `step_out` stays inactive for at least N ticks.
- R5: If a request arrives during a pulse or its mandatory off window, one request is kept. It is issued on the first legal tick, and further requests in that window are dropped. This caps the rate at f_tick/(2N).
- R6: A command of zero produces no pulses.
- R7: When `pulse_lowtrue` is 0, `step_out` is high during a pulse. When it is 1, `step_out` is low during a pulse. During and after reset `step_out` sits at its inactive level.
- R8: The internal direction is 1 for a negative command and 0 otherwise. `dir_out` is that value XOR `dir_invert`, which has no effect on `step_out`.
- R9: `dir_out` changes only on the tick where a pulse front occurs, and it holds until the next front. A sign change between pulses is not visible until the next pulse.
- R10: Reset clears the accumulator, the counters, the pending request and the internal direction (so `dir_out` = `dir_invert`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | CMD_W | Signed velocity command |
| div_sel | input | DIV_W | Tick divider: tick every div_sel+1 clocks |
| width_sel | input | WID_W | Pulse width in ticks (0 treated as 1) |
| pulse_lowtrue | input | 1 | 1 selects an active-low step pulse |
| dir_invert | input | 1 | 1 inverts the direction output |
| step_out | output | 1 | Step pulse output |
| dir_out | output | 1 | Direction output |

## Verification
The bench drives the accumulator at a fixed fraction of the tick rate and at the full magnitude. A design that lost the carry or failed to cap the rate would give a pulse count far from the expected value. Each high run and each inter-pulse low run is measured against N·(div_sel+1) clocks, and each output edge is checked for alignment with the tick phase. This catches an off-by-one width counter, an off window that is too short, or a divider that is off by one. The bench flips the command sign between slow pulses and checks that the direction holds until the next front. A design that passed the sign straight through would show the change early. The bench also checks the idle level under both polarity settings, a zero command, and a width setting of zero.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HIGH = 2'd1,
    SEQ_LOW  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pfm_tick_gen.sv
module pfm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_comb tick = (cnt_q >= div_sel);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0 && $stable(div_sel)) |=> !tick); // R2
endmodule

// File: rtl/pfm_phase_acc.sv
module pfm_phase_acc #(
  parameter int CMD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic signed [CMD_W-1:0] cmd,
  output logic                    req,
  output logic                    req_dir
);
  logic [CMD_W-1:0] acc_q;
  logic [CMD_W-1:0] mag;
  logic [CMD_W:0]   sum;

  always_comb begin
    mag     = cmd[CMD_W-1] ? (~cmd + 1'b1) : cmd;
    sum     = {1'b0, acc_q} + {1'b0, mag};
    req     = tick & sum[CMD_W];
    req_dir = cmd[CMD_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (tick) acc_q <= sum[CMD_W-1:0];
  end

  AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == '0) |-> !req); // R6
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_q)); // R2
endmodule

// File: rtl/pfm_pulse_seq.sv
module pfm_pulse_seq
  import pfm_pkg::*;
#(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req,
  input  logic             req_dir,
  input  logic [WID_W-1:0] width_sel,
  output logic             pulse_raw,
  output logic             dir_raw
);
  seq_state_t       state_q;
  logic [WID_W-1:0] cnt_q;
  logic [WID_W-1:0] n_eff;
  logic             pend_q;
  logic             pend_dir_q;
  logic             dir_q;

  always_comb begin
    n_eff     = (width_sel == '0) ? WID_W'(1) : width_sel;
    pulse_raw = (state_q == SEQ_HIGH);
    dir_raw   = dir_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      pend_dir_q <= 1'b0;
      dir_q      <= 1'b0;
    end else if (tick) begin
      case (state_q)
        SEQ_IDLE: begin
          if (req) begin
            state_q <= SEQ_HIGH;
            cnt_q   <= WID_W'(1);
            dir_q   <= req_dir;
          end
        end
        SEQ_HIGH: begin
          if (cnt_q >= n_eff) begin
            state_q <= SEQ_LOW;
            cnt_q   <= WID_W'(1);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          if (req && !pend_q) begin
            pend_q     <= 1'b1;
            pend_dir_q <= req_dir;
          end
        end
        SEQ_LOW: begin
          if (cnt_q >= n_eff) begin
            if (pend_q) begin
              state_q <= SEQ_HIGH;
              cnt_q   <= WID_W'(1);
              dir_q   <= pend_dir_q;
              pend_q  <= 1'b0;
            end else if (req) begin
              state_q <= SEQ_HIGH;
              cnt_q   <= WID_W'(1);
              dir_q   <= req_dir;
            end else begin
              state_q <= SEQ_IDLE;
              cnt_q   <= '0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (req && !pend_q) begin
              pend_q     <= 1'b1;
              pend_dir_q <= req_dir;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE) |-> !pend_q); // R5
  AST_DIR_AT_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_q) |-> $rose(pulse_raw)); // R9
  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SEQ_HIGH) && $stable(width_sel)) |-> (cnt_q <= n_eff)); // R3
  AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_raw) |-> (state_q == SEQ_LOW)); // R4
endmodule

// File: rtl/pfm_step_gen.sv
module pfm_step_gen #(
  parameter int CMD_W = 16,
  parameter int DIV_W = 8,
  parameter int WID_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [CMD_W-1:0] cmd,
  input  logic [DIV_W-1:0]        div_sel,
  input  logic [WID_W-1:0]        width_sel,
  input  logic                    pulse_lowtrue,
  input  logic                    dir_invert,
  output logic                    step_out,
  output logic                    dir_out
);
  logic tick;
  logic req;
  logic req_dir;
  logic pulse_raw;
  logic dir_raw;

  pfm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick(tick)
  );

  pfm_phase_acc #(.CMD_W(CMD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd),
    .req(req), .req_dir(req_dir)
  );

  pfm_pulse_seq #(.WID_W(WID_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .req_dir(req_dir),
    .width_sel(width_sel), .pulse_raw(pulse_raw), .dir_raw(dir_raw)
  );

  always_comb begin
    step_out = pulse_raw ^ pulse_lowtrue;
    dir_out  = dir_raw ^ dir_invert;
  end

  AST_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pulse_raw) && $stable(dir_raw))); // R2
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (step_out == pulse_lowtrue)); // R7
endmodule

// File: tb/pfm_step_gen_test.sv
module pfm_step_gen_test;
  localparam int CMD_W = 16;
  localparam int DIV_W = 8;
  localparam int WID_W = 8;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic signed [CMD_W-1:0] cmd = '0;
  logic [DIV_W-1:0]        div_sel = '0;
  logic [WID_W-1:0]        width_sel = 8'd1;
  logic                    pulse_lowtrue = 1'b0;
  logic                    dir_invert = 1'b0;
  logic                    step_out;
  logic                    dir_out;

  int n_checks = 0;
  int n_fail   = 0;

  pfm_step_gen #(.CMD_W(CMD_W), .DIV_W(DIV_W), .WID_W(WID_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .div_sel(div_sel),
    .width_sel(width_sel), .pulse_lowtrue(pulse_lowtrue),
    .dir_invert(dir_invert), .step_out(step_out), .dir_out(dir_out)
  );

  always #2 clk = ~clk;

  // monitor state, sampled at falling edges
  int  cyc, fronts, hi_run, lo_run, hi_min, hi_max, lo_min;
  int  phase0, phase_bad, dir_bad;
  bit  seen_front, prev_raw, prev_dir;

  task automatic clear_stats();
    fronts = 0; hi_run = 0; lo_run = 0;
    hi_min = 1 << 30; hi_max = 0; lo_min = 1 << 30;
    phase0 = -1; phase_bad = 0; dir_bad = 0; seen_front = 1'b0;
  endtask

  always @(negedge clk) begin
    bit raw;
    raw = step_out ^ pulse_lowtrue;
    if (!rst_n) begin
      cyc = 0;
      prev_raw = raw;
      prev_dir = dir_out;
    end else begin
      cyc++;
      if (raw != prev_raw) begin
        if (phase0 < 0) phase0 = cyc % (int'(div_sel) + 1);
        else if ((cyc % (int'(div_sel) + 1)) != phase0) phase_bad++;
      end
      if (dir_out != prev_dir && !(raw && !prev_raw)) dir_bad++;
      if (raw && !prev_raw) begin
        fronts++;
        if (seen_front && lo_run < lo_min) lo_min = lo_run;
        seen_front = 1'b1;
        hi_run = 1;
      end else if (!raw && prev_raw) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        lo_run = 1;
      end else if (raw) hi_run++;
      else lo_run++;
      prev_raw = raw;
      prev_dir = dir_out;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic signed [CMD_W-1:0] c, input int dv, input int wd,
                          input bit lt, input bit di);
    @(negedge clk);
    rst_n = 1'b0;
    cmd = c; div_sel = DIV_W'(dv); width_sel = WID_W'(wd);
    pulse_lowtrue = lt; dir_invert = di;
    repeat (3) @(negedge clk);
    clear_stats();
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset(16'sd0, 0, 1, 1'b0, 1'b0);
    #1;
    check(step_out == 1'b0, "R7 idle high-true", step_out, 0);
    check(dir_out == 1'b0, "R10 dir after reset", dir_out, 0);
  endtask

  task automatic t_zero_cmd();
    do_reset(16'sd0, 0, 1, 1'b0, 1'b0);
    run(600);
    check(fronts == 0, "R6 zero command pulses", fronts, 0);
  endtask

  task automatic t_rate();
    do_reset(16'sd16384, 0, 1, 1'b0, 1'b0);
    run(4000);
    check(fronts >= 999 && fronts <= 1001, "R1 rate quarter", fronts, 1000);
    check(dir_out == 1'b0, "R8 positive dir", dir_out, 0);
    check(hi_min == 1 && hi_max == 1, "R3 width 1", hi_max, 1);
  endtask

  task automatic t_width_div();
    do_reset(16'sd4096, 1, 3, 1'b0, 1'b0);
    run(6000);
    check(fronts > 5, "R1 pulses present", fronts, 6);
    check(hi_min == 6 && hi_max == 6, "R3 high run clocks", hi_min, 6);
    check(lo_min >= 6, "R4 low run clocks", lo_min, 6);
    check(phase_bad == 0, "R2 edges on tick", phase_bad, 0);
  endtask

  task automatic t_cap();
    do_reset(-16'sd32768, 0, 2, 1'b0, 1'b0);
    run(4000);
    check(fronts >= 999 && fronts <= 1001, "R5 rate cap", fronts, 1000);
    check(lo_min == 2, "R4 min off at cap", lo_min, 2);
    check(dir_out == 1'b1, "R8 negative dir", dir_out, 1);
  endtask

  task automatic t_width_zero();
    do_reset(16'sd8192, 2, 0, 1'b0, 1'b0);
    run(3000);
    check(hi_min == 3 && hi_max == 3, "R3 width zero as one", hi_max, 3);
    check(phase_bad == 0, "R2 tick phase div2", phase_bad, 0);
  endtask

  task automatic t_dir_latch();
    do_reset(16'sd256, 0, 1, 1'b0, 1'b0);
    run(300);
    check(fronts == 1, "R1 slow first pulse", fronts, 1);
    cmd = -16'sd256;
    run(20);
    check(dir_out == 1'b0, "R9 dir held between pulses", dir_out, 0);
    run(300);
    check(dir_out == 1'b1, "R9 dir after next front", dir_out, 1);
    check(dir_bad == 0, "R9 dir only at front", dir_bad, 0);
  endtask

  task automatic t_polarity();
    do_reset(-16'sd16384, 0, 1, 1'b1, 1'b1);
    #1;
    check(step_out == 1'b1, "R7 idle low-true", step_out, 1);
    check(dir_out == 1'b1, "R10 inverted dir reset", dir_out, 1);
    run(2000);
    check(fronts >= 499 && fronts <= 501, "R7 low-true pulses", fronts, 500);
    check(dir_out == 1'b0, "R8 inverted negative dir", dir_out, 0);
    check(hi_max == 1, "R8 invert leaves width", hi_max, 1);
  endtask

  initial begin
    t_reset_state();
    t_zero_cmd();
    t_rate();
    t_width_div();
    t_cap();
    t_width_zero();
    t_dir_latch();
    t_polarity();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule